// File: doc/BRIEF.md
# Coin Reception Controller

This block follows the value of coins dropped toward a fixed price of 35 cents. Each clock cycle it may see a strobe that marks a 10-cent coin, a strobe that marks a 25-cent coin, or a cancel strobe that empties the running total. The total is held as one of six states: 0, 10, 20, 25, 30 and 35 cents. Any coin that would carry the total to 35 cents or beyond lands in the 35-cent state, and the block stays there.

The single output, `paid_o`, is a registered Moore output. It is high exactly while the machine sits in the 35-cent state, so downstream logic can use it to release goods. All state changes happen on the rising clock edge. Giving change, counting the excess over 35 cents and debouncing the coin sensors are left to other blocks.

Top module: `coin_acceptor`

## Requirements
- R1: While `rst` is high at a rising edge, the total returns to 0 cents and `paid_o` is low after that edge.
- R2: A high `cancel_i` at a rising edge returns the total to 0 cents from every state and takes priority over both coin strobes.
- R3: A high `dime_i` alone moves 0 to 10, 10 to 20, 20 to 30, 25 to 35 and 30 to 35 cents.
- R4: A high `quarter_i` alone moves 0 to 25 cents and moves 10, 20, 25 and 30 cents to 35 cents.
- R5: When `dime_i` and `quarter_i` are both high in one cycle, the quarter is applied and the dime is ignored.
- R6: In the 35-cent state, further dimes or quarters leave the total at 35 cents.
- R7: With no strobe high, the total holds its value across the edge.
- R8: `paid_o` is 1 exactly in the cycles in which the total is 35 cents; it rises right after the edge that enters that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dime_i | input | 1 | One-cycle strobe: a 10-cent coin was accepted |
| quarter_i | input | 1 | One-cycle strobe: a 25-cent coin was accepted |
| cancel_i | input | 1 | One-cycle strobe: empty the running total |
| paid_o | output | 1 | High while the total is 35 cents |

## Verification
Every one of the six states is reached by a fixed coin path and then hit with each input pattern: no strobe, a lone dime, a lone quarter, both coins together, a cancel, and a reset. Because only `paid_o` is visible, a run of probe dimes follows each stimulus. The number of dimes needed before `paid_o` rises tells apart the totals the stimulus could have left, so 10 and 25 cents, or 20 and 35 cents, cannot be confused. The both-coins case separates quarter priority from dime priority. Probing from the 35-cent state shows saturation, and reset from every state shows the return to 0.

// File: rtl/coin_pkg.sv
package coin_pkg;
  localparam int STATE_W = 3;

  // Only the final state has the top bit set with no other bit set.
  typedef enum logic [STATE_W-1:0] {
    ST_0C  = 3'b000,
    ST_10C = 3'b001,
    ST_20C = 3'b010,
    ST_25C = 3'b011,
    ST_30C = 3'b110,
    ST_35C = 3'b100
  } amt_e;
endpackage

// File: rtl/coin_next.sv
module coin_next
  import coin_pkg::*;
(
  input  amt_e cur,
  input  logic dime,
  input  logic quarter,
  input  logic cancel,
  output amt_e nxt
);
  amt_e after_dime;
  amt_e after_quarter;

  always_comb begin
    case (cur)
      ST_0C:   after_dime = ST_10C;
      ST_10C:  after_dime = ST_20C;
      ST_20C:  after_dime = ST_30C;
      ST_25C:  after_dime = ST_35C;
      ST_30C:  after_dime = ST_35C;
      ST_35C:  after_dime = ST_35C;
      default: after_dime = ST_0C;
    endcase
  end

  always_comb begin
    case (cur)
      ST_0C:   after_quarter = ST_25C;
      ST_10C,
      ST_20C,
      ST_25C,
      ST_30C,
      ST_35C:  after_quarter = ST_35C;
      default: after_quarter = ST_0C;
    endcase
  end

  always_comb begin
    if (cancel)
      nxt = ST_0C;
    else if (quarter)
      nxt = after_quarter;
    else if (dime)
      nxt = after_dime;
    else if (cur inside {ST_0C, ST_10C, ST_20C, ST_25C, ST_30C, ST_35C})
      nxt = cur;
    else
      nxt = ST_0C;
  end
endmodule

// File: rtl/coin_state_reg.sv
module coin_state_reg
  import coin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  amt_e nxt,
  output amt_e state_q,
  output logic paid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_0C;
      paid_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      paid_q  <= (nxt == ST_35C);
    end
  end

  // The separate output flop must follow the state register.
  assert_paid_matches_state_R8: assert property (@(posedge clk) disable iff (rst)
    paid_q == (state_q == ST_35C));

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_0C) && !paid_q);
endmodule

// File: rtl/coin_acceptor.sv
module coin_acceptor
  import coin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dime_i,
  input  logic quarter_i,
  input  logic cancel_i,
  output logic paid_o
);
  amt_e state_q;
  amt_e nxt;
  logic paid_q;

  coin_next u_next (
    .cur     (state_q),
    .dime    (dime_i),
    .quarter (quarter_i),
    .cancel  (cancel_i),
    .nxt     (nxt)
  );

  coin_state_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt),
    .state_q (state_q),
    .paid_q  (paid_q)
  );

  assign paid_o = paid_q;

  assert_cancel_empties_R2: assert property (@(posedge clk) disable iff (rst)
    cancel_i |=> state_q == ST_0C);

  assert_quarter_from_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_0C && quarter_i && !cancel_i) |=> state_q == ST_25C);

  assert_both_coins_quarter_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_0C && quarter_i && dime_i && !cancel_i) |=> state_q == ST_25C);

  assert_saturate_at_price_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_35C && !cancel_i) |=> state_q == ST_35C);

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!dime_i && !quarter_i && !cancel_i) |=> $stable(state_q));

  assert_dime_from_twenty_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_20C && dime_i && !quarter_i && !cancel_i) |=> state_q == ST_30C);
endmodule

// File: tb/test_coin_acceptor.sv
module test_coin_acceptor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dime_i = 1'b0;
  logic quarter_i = 1'b0;
  logic cancel_i = 1'b0;
  logic paid_o;

  int total_chk = 0;
  int bad_chk = 0;
  int cycles = 0;
  int model_cents = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  coin_acceptor i_coin_acceptor (
    .clk       (clk),
    .rst       (rst),
    .dime_i    (dime_i),
    .quarter_i (quarter_i),
    .cancel_i  (cancel_i),
    .paid_o    (paid_o)
  );

  task automatic report_end();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total_chk = total_chk + 1;
      bad_chk = bad_chk + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      report_end();
    end
  end

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input bit d, input bit q, input bit c, input bit r, input string tag);
    dime_i = d;
    quarter_i = q;
    cancel_i = c;
    rst = r;
    @(posedge clk);
    if (r || c)
      model_cents = 0;
    else if (q)
      model_cents = (model_cents + 25 > 35) ? 35 : model_cents + 25;
    else if (d)
      model_cents = (model_cents + 10 > 35) ? 35 : model_cents + 10;
    @(negedge clk);
    total_chk = total_chk + 1;
    if (paid_o !== (model_cents == 35)) begin
      bad_chk = bad_chk + 1;
      $display("FAIL %s: total=%0d act=%b exp=%b", tag, model_cents, paid_o, model_cents == 35);
    end
  endtask

  task automatic go_to(input int idx);
    step(0, 0, 1, 0, "R2 setup");
    case (idx)
      1: step(1, 0, 0, 0, "R3 to10");
      2: begin step(1, 0, 0, 0, "R3 to10"); step(1, 0, 0, 0, "R3 to20"); end
      3: step(0, 1, 0, 0, "R4 to25");
      4: begin
           step(1, 0, 0, 0, "R3 to10");
           step(1, 0, 0, 0, "R3 to20");
           step(1, 0, 0, 0, "R3 to30");
         end
      5: begin step(0, 1, 0, 0, "R4 to25"); step(1, 0, 0, 0, "R8 to35"); end
      default: ;
    endcase
  endtask

  initial begin
    @(negedge clk);
    step(0, 0, 0, 1, "R1 reset");
    step(0, 0, 0, 1, "R1 reset");
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 6; k++) begin
        go_to(s);
        case (k)
          0: step(0, 0, 0, 0, "R7 idle");
          1: step(1, 0, 0, 0, "R3 dime");
          2: step(0, 1, 0, 0, "R4 quarter");
          3: step(1, 1, 0, 0, "R5 both");
          4: step(1, 1, 1, 0, "R2 cancel");
          default: step(1, 0, 0, 1, "R1 reset");
        endcase
        for (int p = 0; p < 4; p++)
          step(1, 0, 0, 0, (s == 5) ? "R6 saturate" : "R8 probe");
      end
    end
    go_to(5);
    for (int p = 0; p < 3; p++) step(0, 1, 0, 0, "R6 quarter at 35");
    for (int p = 0; p < 3; p++) step(0, 0, 0, 0, "R7 hold at 35");
    step(0, 0, 1, 0, "R2 cancel at 35");
    step(0, 0, 0, 0, "R7 hold at 0");
    report_end();
  end
endmodule